// File: doc/BRIEF.md
# LED-Selector I2C Port Expander

This block is an I2C target holding sixteen general-purpose pins and a small register file. Every pin has a 2-bit selector. The selector can pull the pin low, let it float so that the board pull-up makes it read high, or hand it to one of two blink generators. Each blink generator has its own period register and duty register. Pin levels pass through a two-flop synchronizer and are presented continuously in two byte-wide input registers, so that a host can read back what the wire really shows.

A host first sends the 7-bit target address with the write bit, then a pointer byte. After that it either sends data bytes, which all land in the pointed register, or it issues a repeated START and reads. Reads keep returning the pointed register until the host answers NACK. The blink counters advance on `blink_tick`, a one-cycle enable taken from a slow prescale clock.

The bus engine is a single state machine with these states:
- **IDLE**: off the bus.
- **ADDR**: shifts in the address byte.
- **ACK_ADDR**: acknowledges a matching address.
- **RX**: receives a pointer or data byte.
- **ACK_RX**: acknowledges a received byte.
- **TX**: shifts a byte out.
- **ACK_TX**: samples the host's acknowledge.

Its transitions are:
- START moves from any state to ADDR.
- STOP moves from any state to IDLE.
- ADDR goes to ACK_ADDR on a matching address and to IDLE on any other.
- ACK_ADDR goes to TX for a read and to RX for a write.
- RX goes to ACK_RX, and ACK_RX goes back to RX.
- TX goes to ACK_TX.
- ACK_TX goes back to TX on ACK and to IDLE on NACK.

Top module: `ledx_expander`

## Requirements
- R1: The target acknowledges only the address on `dev_addr`. For any other address, SDA stays released on the ninth clock and the bytes that follow change no register.
- R2: In a write, the first byte after the address is the pointer. Every later byte in the same transfer is written to that same register, with no increment.
- R3: A read returns the register chosen by the last pointer byte. Further bytes acknowledged by the host repeat the same register, and a host NACK ends the transfer.
- R4: After reset the selector registers hold 0x55, the period registers hold 0xFF and the duty registers hold 0x80. No pin is driven low, so both input registers read 0xFF.
- R5: Pin n is controlled by selector register n/4, in bits [2(n mod 4)+1 : 2(n mod 4)]. Field value 0 drives the pin low and value 1 releases it.
- R6: Pointer 0 returns pins 7..0 and pointer 1 returns pins 15..8, with bit i holding the pin level, after a two-flop synchronizer.
- R7: Field value 2 drives the pin from blink generator 0 and value 3 drives it from generator 1. A generator's counter advances on each `blink_tick` and wraps to 0 after reaching its period value, giving a period of (period+1) ticks. The pin is driven low while the counter is below the duty value.
- R8: The pointer map is 0–1 inputs, 2 period0, 3 duty0, 4 period1, 5 duty1, and 6–9 selectors. A pointer above 9 is acknowledged, writes to it are ignored and reads from it return 0.
- R9: A STOP at any point returns to IDLE, so that a byte cut short writes nothing. A START at any point restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock level |
| sda_i | input | 1 | I2C data level |
| sda_drv_low | output | 1 | Pull SDA low when high |
| dev_addr | input | 7 | Configured 7-bit target address |
| blink_tick | input | 1 | One-cycle prescale enable for the blink counters |
| pin_i | input | NPINS | Sensed pin levels |
| pin_drv_low | output | NPINS | Pull pin low when high |

## Verification
The in-line assertions check, on every cycle:
- SDA is never pulled during IDLE or address reception.
- A mismatched address returns the engine to IDLE.
- A STOP always lands in IDLE.
- A write strobe lasts one cycle.
- A write to an unmapped pointer leaves every register unchanged.
- A blink counter never passes its period after a tick.
- A released selector never drives its pin.

The bench's scenarios are needed for the rest, because these depend on complete bus transfers and external wiring:
- The pointer-then-data ordering.
- Repeated reads of the same register.
- The field position of each pin.
- The input read-back through a loop that ties pins 0–4 to pins 5–9.
- The drive pattern over a blink period.

// File: rtl/ledx_pkg.sv
package ledx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_RX,
        ST_ACK_RX,
        ST_TX,
        ST_ACK_TX
    } bus_state_t;

    localparam int BYTE_W = 8;
    localparam int NBLINK = 2;
endpackage

// File: rtl/ledx_i2c_target.sv
module ledx_i2c_target
    import ledx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic [6:0]  dev_addr,
    input  logic [7:0]  rd_data,
    output logic        sda_drv_low,
    output logic        wr_en,
    output logic [7:0]  wr_data,
    output logic [7:0]  ptr
);
    logic [2:0] scl_p, sda_p;
    logic       scl_rise, scl_fall, start_c, stop_c;
    bus_state_t state;
    logic [3:0] cnt;
    logic [7:0] sh;
    logic       rw, first, nack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 3'b111;
            sda_p <= 3'b111;
        end else begin
            scl_p <= {scl_p[1:0], scl_i};
            sda_p <= {sda_p[1:0], sda_i};
        end
    end

    assign scl_rise = scl_p[1] && !scl_p[2];
    assign scl_fall = !scl_p[1] && scl_p[2];
    assign start_c  = scl_p[1] && scl_p[2] && sda_p[2] && !sda_p[1];
    assign stop_c   = scl_p[1] && scl_p[2] && !sda_p[2] && sda_p[1];

    // state register and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            sh    <= '0;
            rw    <= 1'b0;
            first <= 1'b0;
            nack  <= 1'b0;
            ptr   <= '0;
        end else if (stop_c) begin
            state <= ST_IDLE;
        end else if (start_c) begin
            state <= ST_ADDR;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise) begin
                        sh  <= {sh[6:0], sda_p[1]};
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall && cnt == 4'd8) begin
                        cnt <= '0;
                        if (sh[7:1] == dev_addr) begin
                            rw    <= sh[0];
                            state <= ST_ACK_ADDR;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (scl_fall) begin
                        if (rw) begin
                            state <= ST_TX;
                            sh    <= rd_data;
                        end else begin
                            state <= ST_RX;
                            first <= 1'b1;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        sh  <= {sh[6:0], sda_p[1]};
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall && cnt == 4'd8) begin
                        cnt   <= '0;
                        state <= ST_ACK_RX;
                        if (first) ptr <= sh;
                    end
                end
                ST_ACK_RX: begin
                    if (scl_fall) begin
                        state <= ST_RX;
                        first <= 1'b0;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (cnt == 4'd8) begin
                            cnt   <= '0;
                            state <= ST_ACK_TX;
                        end else begin
                            sh <= {sh[6:0], 1'b0};
                        end
                    end
                end
                ST_ACK_TX: begin
                    if (scl_rise) begin
                        nack <= sda_p[1];
                    end else if (scl_fall) begin
                        if (nack) begin
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_TX;
                            sh    <= rd_data;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_drv_low = 1'b0;
        wr_en       = 1'b0;
        wr_data     = sh;
        unique case (state)
            ST_ACK_ADDR, ST_ACK_RX: sda_drv_low = 1'b1;
            ST_TX:                  sda_drv_low = !sh[7];
            ST_RX:                  wr_en = scl_fall && cnt == 4'd8 && !first
                                            && !start_c && !stop_c;
            default: ;
        endcase
    end

    p_quiet_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_ADDR) |-> !sda_drv_low);

    p_mismatch_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && cnt == 4'd8 && sh[7:1] != dev_addr
         && !start_c && !stop_c) |=> state == ST_IDLE);

    p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> state == ST_IDLE);

    p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

// File: rtl/ledx_regs.sv
module ledx_regs
    import ledx_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [7:0]                   ptr,
    input  logic [7:0]                   wr_data,
    input  logic [NPINS-1:0]             pin_i,
    output logic [7:0]                   rd_data,
    output logic [NBLINK-1:0][7:0]       period,
    output logic [NBLINK-1:0][7:0]       duty,
    output logic [2*NPINS-1:0]           sel
);
    localparam int NIN    = NPINS / 8;
    localparam int NSEL   = NPINS / 4;
    localparam int P_PER0 = NIN;
    localparam int P_SEL0 = NIN + 2 * NBLINK;
    localparam int P_LAST = P_SEL0 + NSEL - 1;

    logic [NPINS-1:0] in_m, in_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_m <= '1;
            in_q <= '1;
        end else begin
            in_m <= pin_i;
            in_q <= in_m;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period <= {NBLINK{8'hFF}};
            duty   <= {NBLINK{8'h80}};
            sel    <= {NSEL{8'h55}};
        end else if (wr_en) begin
            for (int k = 0; k < NBLINK; k++) begin
                if (ptr == 8'(P_PER0 + 2 * k))     period[k] <= wr_data;
                if (ptr == 8'(P_PER0 + 2 * k + 1)) duty[k]   <= wr_data;
            end
            for (int k = 0; k < NSEL; k++) begin
                if (ptr == 8'(P_SEL0 + k)) sel[8*k +: 8] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NIN; k++)
            if (ptr == 8'(k)) rd_data = in_q[8*k +: 8];
        for (int k = 0; k < NBLINK; k++) begin
            if (ptr == 8'(P_PER0 + 2 * k))     rd_data = period[k];
            if (ptr == 8'(P_PER0 + 2 * k + 1)) rd_data = duty[k];
        end
        for (int k = 0; k < NSEL; k++)
            if (ptr == 8'(P_SEL0 + k)) rd_data = sel[8*k +: 8];
    end

    p_unmapped_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr > 8'(P_LAST)) |=>
        (sel == $past(sel) && period == $past(period) && duty == $past(duty)));
endmodule

// File: rtl/ledx_blink.sv
module ledx_blink (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [7:0] period,
    input  logic [7:0] duty,
    output logic       blink_low
);
    logic [7:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= (cnt >= period) ? 8'd0 : cnt + 8'd1;
    end

    assign blink_low = cnt < duty;

    p_cnt_in_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt <= $past(period));
endmodule

// File: rtl/ledx_expander.sv
module ledx_expander
    import ledx_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_drv_low,
    input  logic [6:0]       dev_addr,
    input  logic             blink_tick,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] pin_drv_low
);
    logic                   wr_en;
    logic [7:0]             wr_data, ptr, rd_data;
    logic [NBLINK-1:0][7:0] period, duty;
    logic [2*NPINS-1:0]     sel;
    logic [NBLINK-1:0]      blink_low;

    ledx_i2c_target i_bus (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .dev_addr(dev_addr), .rd_data(rd_data), .sda_drv_low(sda_drv_low),
        .wr_en(wr_en), .wr_data(wr_data), .ptr(ptr)
    );

    ledx_regs #(.NPINS(NPINS)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ptr(ptr),
        .wr_data(wr_data), .pin_i(pin_i), .rd_data(rd_data),
        .period(period), .duty(duty), .sel(sel)
    );

    for (genvar b = 0; b < NBLINK; b++) begin : g_blink
        ledx_blink i_blink (
            .clk(clk), .rst_n(rst_n), .tick(blink_tick),
            .period(period[b]), .duty(duty[b]), .blink_low(blink_low[b])
        );
    end

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        always_comb begin
            unique case (sel[2*n +: 2])
                2'd0:    pin_drv_low[n] = 1'b1;
                2'd1:    pin_drv_low[n] = 1'b0;
                2'd2:    pin_drv_low[n] = blink_low[0];
                default: pin_drv_low[n] = blink_low[1];
            endcase
        end

        p_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[2*n +: 2] == 2'd1) |-> !pin_drv_low[n]);
    end
endmodule

// File: tb/test_ledx_expander.sv
`timescale 1ns/1ps
module test_ledx_expander;
    localparam int NPINS = 16;
    localparam time Q = 40ns;
    localparam logic [6:0] DEV = 7'h63;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    logic tick = 1'b0;
    logic sda_drv_low, sda_bus;
    logic [NPINS-1:0] pin_drv_low, pin_lvl;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    assign sda_bus = !(m_sda_low || sda_drv_low);
    // pins 0..4 are wired to pins 5..9 on the board
    assign pin_lvl = ~pin_drv_low & ~{6'b0, pin_drv_low[4:0], 5'b0};

    ledx_expander #(.NPINS(NPINS)) i_ledx_expander (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_drv_low(sda_drv_low), .dev_addr(DEV), .blink_tick(tick),
        .pin_i(pin_lvl), .pin_drv_low(pin_drv_low)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; #Q;
        m_scl = 1'b1;     #Q;
        m_sda_low = 1'b1; #Q;
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; #Q;
        m_scl = 1'b1;     #Q;
        m_sda_low = 1'b0; #Q;
    endtask

    task automatic bus_bit(input logic b, output logic s);
        m_sda_low = !b; #Q;
        m_scl = 1'b1;   #Q;
        s = sda_bus;    #Q;
        m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            b[i] = s;
        end
        bus_bit(!host_ack, s);
        m_sda_low = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] p, input logic [7:0] d);
        logic a;
        bus_start();
        send_byte({DEV, 1'b0}, a); chk("R1 address ack", a, 1);
        send_byte(p, a);           chk("R8 pointer ack", a, 1);
        send_byte(d, a);           chk("R2 data ack", a, 1);
        bus_stop();
    endtask

    task automatic reg_read(input logic [7:0] p, output logic [7:0] d);
        logic a;
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(p, a);
        bus_start();
        send_byte({DEV, 1'b1}, a); chk("R3 read address ack", a, 1);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic expect_reg(input string req, input logic [7:0] p, input logic [7:0] exp);
        logic [7:0] d;
        reg_read(p, d);
        chk(req, d, exp);
    endtask

    task automatic expect_pins(input string req, input logic [15:0] exp);
        logic [7:0] lo, hi;
        reg_read(8'd0, lo);
        reg_read(8'd1, hi);
        chk(req, {hi, lo}, exp);
    endtask

    task automatic t_reset();
        chk("R4 no pin driven", pin_drv_low, 16'h0000);
        chk("R4 sda released", sda_drv_low, 0);
        expect_reg("R4 period0", 8'd2, 8'hFF);
        expect_reg("R4 duty0", 8'd3, 8'h80);
        expect_reg("R4 period1", 8'd4, 8'hFF);
        expect_reg("R4 duty1", 8'd5, 8'h80);
        for (int k = 0; k < 4; k++) expect_reg("R4 selector", 8'(6 + k), 8'h55);
        expect_pins("R4 R6 inputs all high", 16'hFFFF);
    endtask

    task automatic t_wrong_addr();
        logic a;
        bus_start();
        send_byte({7'h22, 1'b0}, a); chk("R1 foreign address not acked", a, 0);
        send_byte(8'd6, a);          chk("R1 no ack after foreign address", a, 0);
        send_byte(8'h00, a);
        bus_stop();
        expect_reg("R1 selector0 untouched", 8'd6, 8'h55);
    endtask

    task automatic t_pin_drive();
        reg_write(8'd6, 8'h54);
        chk("R5 pin0 driven", pin_drv_low, 16'h0001);
        expect_pins("R6 pin0 low", 16'hFFDE);
        reg_write(8'd6, 8'h50); expect_pins("R6 pins0-1 low", 16'hFF9C);
        reg_write(8'd6, 8'h40); expect_pins("R6 pins0-2 low", 16'hFF18);
        reg_write(8'd6, 8'h00); expect_pins("R6 pins0-3 low", 16'hFE10);
        reg_write(8'd7, 8'h54); expect_pins("R5 pin4 via selector1", 16'hFC00);
        reg_write(8'd6, 8'h55);
        reg_write(8'd7, 8'h55);
        expect_pins("R5 all released again", 16'hFFFF);
        reg_write(8'd9, 8'h15);
        chk("R5 pin15 field bits 7:6", pin_drv_low, 16'h8000);
        expect_pins("R6 pin15 in upper input byte", 16'h7FFF);
        reg_write(8'd9, 8'h55);
    endtask

    task automatic t_multi_write();
        logic a;
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd3, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a); chk("R2 second data acked", a, 1);
        bus_stop();
        expect_reg("R2 same register holds last byte", 8'd3, 8'h22);
        expect_reg("R2 next register untouched", 8'd4, 8'hFF);
    endtask

    task automatic t_multi_read();
        logic a;
        logic [7:0] b1, b2;
        reg_write(8'd8, 8'h5A);
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd8, a);
        bus_start();
        send_byte({DEV, 1'b1}, a);
        recv_byte(1'b1, b1);
        recv_byte(1'b0, b2);
        bus_stop();
        chk("R3 first read byte", b1, 8'h5A);
        chk("R3 repeated read byte", b2, 8'h5A);
        chk("R3 sda released after nack", sda_drv_low, 0);
        reg_write(8'd8, 8'h55);
    endtask

    task automatic t_bad_ptr();
        reg_write(8'd12, 8'h00);
        expect_reg("R8 unmapped read zero", 8'd12, 8'h00);
        expect_reg("R8 pointer 10 reads zero", 8'd10, 8'h00);
        for (int k = 0; k < 4; k++) expect_reg("R8 selectors unchanged", 8'(6 + k), 8'h55);
        chk("R8 no pin driven", pin_drv_low, 16'h0000);
    endtask

    task automatic t_abort();
        logic a, s;
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd7, a);
        for (int i = 0; i < 4; i++) bus_bit(1'b0, s);
        bus_stop();
        expect_reg("R9 cut byte writes nothing", 8'd7, 8'h55);
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd6, a);
        bus_start();
        send_byte({DEV, 1'b0}, a); chk("R9 restart address acked", a, 1);
        send_byte(8'd7, a);
        send_byte(8'h51, a);
        bus_stop();
        expect_reg("R9 pointer from restarted transfer", 8'd7, 8'h51);
        expect_reg("R9 earlier pointer untouched", 8'd6, 8'h55);
        reg_write(8'd7, 8'h55);
    endtask

    task automatic t_blink();
        int c0 = 0;
        int ticks = 0;
        reg_write(8'd2, 8'd3);
        reg_write(8'd3, 8'd2);
        reg_write(8'd6, 8'h56);
        reg_write(8'd7, 8'h57);
        @(negedge clk);
        chk("R7 blink0 low at count 0", pin_drv_low[0], 1);
        chk("R7 selector3 pin4 driven", pin_drv_low[4], 1);
        for (int i = 0; i < 8; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            ticks++;
            c0 = (c0 >= 3) ? 0 : c0 + 1;
            chk("R7 blink0 waveform", pin_drv_low[0], (c0 < 2) ? 1 : 0);
            chk("R7 released neighbour", pin_drv_low[1], 0);
        end
        chk("R7 blink1 still under duty", pin_drv_low[4], (ticks < 128) ? 1 : 0);
        reg_write(8'd6, 8'h55);
        reg_write(8'd7, 8'h55);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_wrong_addr();
        t_pin_drive();
        t_multi_write();
        t_multi_read();
        t_bad_ptr();
        t_abort();
        t_blink();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule